// File: doc/BRIEF.md
# Selectable-Length Stereo Sample Delay

This block delays a stereo stream of 24-bit words by one of four fixed lengths, picked by a 2-bit length-select input. Each sample arrives as one strobe carrying a left and a right word. The words go into a circular sample RAM and are read back the selected number of strobes later. The block does not look at the data, so any bit pattern passes through unchanged. The output has the same word format as the input, so several instances can be chained to build a longer line.

The length-select input is asynchronous to the block clock and passes through a two-stage synchroniser. When its synchronised value differs from the stored setting, the block restarts. The write pointer returns to zero and a mute period as long as the new delay begins. During that period the outputs read zero and the incoming samples are discarded: the buffer is filled with zeros in their place. Power-on RAM content is therefore never visible.

Top module: `stereo_delay`

## Requirements
- R1: The delay L counts strobes. The output on strobe j carries the input of strobe j−L. L is 1026 for select 2'b00, 2050 for 2'b10, 3074 for 2'b01 and 4098 for 2'b11 (one more than the sample counts 1025, 2049, 3073 and 4097).
- R2: `valid_o` is high exactly one clock after each cycle in which `smp_valid_i` is high, and low otherwise. `left_o`, `right_o` and `muted_o` take their new values in that same cycle.
- R3: Between output strobes, `left_o`, `right_o` and `muted_o` hold their values.
- R4: Words pass through bit-exact, including all-ones, all-zeros and sign-bit patterns. Left stays on left and right stays on right.
- R5: A change of `mode_i` takes effect at the third rising clock edge after it. Strobes from then on are counted from zero under the new length.
- R6: For the first L strobes after a restart, `muted_o` is 1 and both output words are zero.
- R7: Samples that arrive during the mute period are discarded. The L strobes that follow the mute period therefore also output zero words, with `muted_o` at 0.
- R8: While `rst_ni` is low, `valid_o` is 0, `muted_o` is 1 and both output words are zero. After reset the setting 2'b00 is in force, with its mute period running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Delay length select, asynchronous |
| smp_valid_i | input | 1 | One-cycle strobe per stereo sample |
| left_i | input | 24 | Left input word |
| right_i | input | 24 | Right input word |
| valid_o | output | 1 | Output sample strobe |
| left_o | output | 24 | Delayed left word |
| right_o | output | 24 | Delayed right word |
| muted_o | output | 1 | Output is in the post-restart mute period |

## Verification
Each strobe's result appears one clock after the strobe edge. It passes through one register stage: the synchronous RAM read and the mute flag, which are updated together. The bench drives inputs on falling edges and samples each result on the falling edge that follows the capturing rising edge. It also looks again one cycle later to confirm that the values hold. After a change of `mode_i` the bench waits five idle cycles, which covers the three edges of the restart path, before it sends the first counted strobe. Expected words come from a function of the strobe index, with index j−L used for the delayed value.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  typedef enum logic [1:0] {
    LEN_Q1 = 2'b00,
    LEN_Q3 = 2'b01,
    LEN_Q2 = 2'b10,
    LEN_Q4 = 2'b11
  } len_mode_e;

  // quarter steps selected by each code; code order is fixed by the pins
  function automatic int unsigned quarters(logic [1:0] m);
    unique case (len_mode_e'(m))
      LEN_Q1:  return 1;
      LEN_Q2:  return 2;
      LEN_Q3:  return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/sdl_mode_sync.sv
module sdl_mode_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;
endmodule

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
#(
  parameter int unsigned STEP_LEN = 1024,
  parameter int unsigned PTR_W    = 13,
  parameter int unsigned CNT_W    = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             strobe_i,
  output logic             chg_o,
  output logic             strobe_ok_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             mute_o,
  output logic [CNT_W-1:0] cur_len_o
);
  function automatic logic [CNT_W-1:0] len_of(logic [1:0] m);
    return CNT_W'(STEP_LEN * quarters(m) + 2);
  endfunction

  logic [1:0]       mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_cur;
  logic             last;

  assign len_cur = len_of(mode_q);
  assign chg_o   = (mode_i != mode_q);
  assign last    = (CNT_W'(ptr_q) == len_cur - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 2'b00;
      ptr_q  <= '0;
      cnt_q  <= len_of(2'b00);
    end else if (chg_o) begin
      mode_q <= mode_i;
      ptr_q  <= '0;
      cnt_q  <= len_of(mode_i);
    end else if (strobe_i) begin
      ptr_q <= last ? '0 : ptr_q + PTR_W'(1);
      if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign strobe_ok_o = strobe_i & ~chg_o;
  assign wr_ptr_o    = ptr_q;
  assign mute_o      = (cnt_q != '0);
  assign cur_len_o   = len_cur;
endmodule

// File: rtl/sdl_ram.sv
module sdl_ram #(
  parameter int unsigned W     = 48,
  parameter int unsigned DEPTH = 4098,
  parameter int unsigned AW    = 13
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rd_q;

  // read-before-write on the same address
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rd_q         <= mem[addr_i];
      mem[addr_i]  <= wdata_i;
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/stereo_delay.sv
module stereo_delay #(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned STEP_LEN = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              muted_o
);
  localparam int unsigned MAX_LEN = 4 * STEP_LEN + 2;
  localparam int unsigned PTR_W   = $clog2(MAX_LEN);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned WORD_W  = 2 * DATA_W;

  logic [1:0]       mode_sync;
  logic             chg, strobe_ok, mute_now;
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] cur_len;
  logic [WORD_W-1:0] wdata, rdata;
  logic             valid_q, mute_q;

  sdl_mode_sync #(.W(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (mode_i),
    .sync_o  (mode_sync)
  );

  sdl_ctrl #(.STEP_LEN(STEP_LEN), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_sync),
    .strobe_i    (smp_valid_i),
    .chg_o       (chg),
    .strobe_ok_o (strobe_ok),
    .wr_ptr_o    (wr_ptr),
    .mute_o      (mute_now),
    .cur_len_o   (cur_len)
  );

  // discarded samples are replaced by zeros, flushing the line
  assign wdata = mute_now ? '0 : {left_i, right_i};

  sdl_ram #(.W(WORD_W), .DEPTH(MAX_LEN), .AW(PTR_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (strobe_ok),
    .addr_i  (wr_ptr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      mute_q  <= 1'b1;
    end else begin
      valid_q <= smp_valid_i;
      if (smp_valid_i) mute_q <= chg | mute_now;
    end
  end

  assign valid_o = valid_q;
  assign muted_o = mute_q;
  assign left_o  = mute_q ? '0 : rdata[WORD_W-1:DATA_W];
  assign right_o = mute_q ? '0 : rdata[DATA_W-1:0];
endmodule

// File: rtl/stereo_delay_chk.sv
module stereo_delay_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned PTR_W  = 13,
  parameter int unsigned CNT_W  = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic              muted_o,
  input logic              chg,
  input logic              mute_now,
  input logic [PTR_W-1:0]  wr_ptr,
  input logic [CNT_W-1:0]  cur_len
);
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> valid_o); // R2
  AST_NO_SPUR_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> !valid_o); // R2
  AST_MUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    muted_o |-> (left_o == '0 && right_o == '0)); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && $past(rst_ni)) |-> ($stable(left_o) && $stable(right_o) && $stable(muted_o))); // R3
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> (wr_ptr == '0 && mute_now)); // R5
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(wr_ptr) < cur_len); // R1
endmodule

bind stereo_delay stereo_delay_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .valid_o     (valid_o),
  .left_o      (left_o),
  .right_o     (right_o),
  .muted_o     (muted_o),
  .chg         (chg),
  .mute_now    (mute_now),
  .wr_ptr      (wr_ptr),
  .cur_len     (cur_len)
);

// File: tb/stereo_delay_tb_top.sv
`timescale 1ns/1ps
module stereo_delay_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sv = 1'b0;
  logic [23:0] li = '0, ri = '0;
  logic        vo, mo;
  logic [23:0] lo, ro;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  stereo_delay dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_i      (mode),
    .smp_valid_i (sv),
    .left_i      (li),
    .right_i     (ri),
    .valid_o     (vo),
    .left_o      (lo),
    .right_o     (ro),
    .muted_o     (mo)
  );

  // {select, expected length}: R1 table
  localparam logic [17:0] MODE_TAB [4] = '{
    {2'b00, 16'd1026},
    {2'b10, 16'd2050},
    {2'b01, 16'd3074},
    {2'b11, 16'd4098}
  };

  function automatic logic [23:0] dat_l(int j);
    logic [31:0] h;
    h = j * 32'h9E3779B1;
    case (j % 6)
      0: return 24'hFFFFFF;
      1: return 24'h800000;
      2: return 24'h000000;
      default: return h[28:5];
    endcase
  endfunction

  function automatic logic [23:0] dat_r(int j);
    return ~dat_l(j) ^ 24'(j);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mode  = 2'b00;
    sv    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 valid", 64'(vo), 64'd0);
    chk("R8 muted", 64'(mo), 64'd1);
    chk("R8 left",  64'(lo), 64'd0);
    chk("R8 right", 64'(ro), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    mode = m;
    repeat (5) @(negedge clk);   // R5: restart done after three edges
  endtask

  // strobes 0..n-1 after restart; L is the expected delay
  task automatic run(int L, int n);
    logic [23:0] el, er, pl, pr;
    logic        em, pm;
    for (int j = 0; j < n; j++) begin
      li = dat_l(j);
      ri = dat_r(j);
      sv = 1'b1;
      @(negedge clk);
      sv = 1'b0;
      li = '0;
      ri = '0;
      em = (j < L);
      el = (j < 2 * L) ? 24'd0 : dat_l(j - L);
      er = (j < 2 * L) ? 24'd0 : dat_r(j - L);
      chk("R2 valid", 64'(vo), 64'd1);
      if (j < L) begin
        chk("R6 muted", 64'(mo), 64'(em));
        chk("R6 left",  64'(lo), 64'(el));
      end else if (j < 2 * L) begin
        chk("R7 muted", 64'(mo), 64'(em));
        chk("R7 left",  64'(lo), 64'(el));
        chk("R7 right", 64'(ro), 64'(er));
      end else begin
        chk("R1 left",  64'(lo), 64'(el));
        chk("R4 right", 64'(ro), 64'(er));
        chk("R1 muted", 64'(mo), 64'(em));
      end
      pl = lo; pr = ro; pm = mo;
      @(negedge clk);
      if (j % 64 == 0) begin
        chk("R2 valid low", 64'(vo), 64'd0);
        chk("R3 hold", {15'd0, pm, pl, pr}, {15'd0, mo, lo, ro});
      end
    end
  endtask

  initial begin
    do_reset();
    // table walk: each select from a fresh restart
    for (int k = 0; k < 4; k++) begin
      set_mode(MODE_TAB[k][17:16]);
      run(int'(MODE_TAB[k][15:0]), 3 * int'(MODE_TAB[k][15:0]));
    end
    // R5: change during an active mute period restarts with the new length
    set_mode(2'b10);
    run(2050, 100);
    set_mode(2'b00);
    run(1026, 3 * 1026);
    // R8: reset in mid-stream
    do_reset();
    run(1026, 2 * 1026 + 20);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule